// File: doc/BRIEF.md
# Associative Memory Pattern Bank

This block is a compact associative memory for finding coincidences across several independent data streams. It stores 64 patterns. Each pattern has one 16-bit reference word for each of eight layers. Each layer has its own input bus with its own valid bit.

In every cycle, each cell compares the word on its layer's bus against its stored word. Each cell can be told to ignore a number of low-order bits during that comparison. A hit sets a per-cell flag, and the flag stays set until the next event clear. Because of this, the layers that complete a pattern may arrive in different cycles.

Each pattern counts its flagged layers and compares the count with a shared threshold. A pattern fires once its count reaches the threshold, so some layers may be missing. Fired addresses leave the block through a valid/ready stream, lowest address first. Each address is reported once per event.

Patterns are written through a simple write port during training, and they may be rewritten later. The output stream follows the usual back-pressure rules:
- While `res_valid` is high and `res_ready` is low, the address holds steady.
- A transfer happens on any clock edge where both are high.
- The block never withdraws an offered address, except on an event clear.

Top module: `am_pattern_bank`

## Requirements
- R1: A write with `ld_en` high and `evt_clr` low stores `ld_word` and `ld_ign` into the cell selected by `ld_pat` and `ld_layer`. The stored values are used from the next cycle on. A write presented while `evt_clr` is high is dropped, and the old contents stay.
- R2: When `bus_valid[l]` is high, layer l's cell in a pattern matches if the bus word and the stored word agree in every bit above the ignored low bits. The word of layer l occupies `bus_word[16*l+15 : 16*l]`. A word presented with its valid bit low has no effect.
- R3: A cell's match flag, once set, stays set until `evt_clr`. A pattern may therefore be completed by hits spread over many cycles, in any layer order.
- R4: The stored ignore code n makes the cell ignore its n least significant bits when n is 2 to 6. Codes 0 and 1 behave as 2, and code 7 behaves as 6.
- R5: A pattern fires when its number of flagged layers is at least `thr`. A `thr` of 0 behaves as 1.
- R6: After a hit is sampled on edge k, a pattern that fires because of it is offered on `res_addr` after edge k+1. Patterns pending at the same time are offered in ascending address order, one per cycle while `res_ready` stays high.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_addr` remain unchanged.
- R8: Within one event, each pattern is offered at most once, even if it is hit again.
- R9: `res_done` is high exactly when no address is being offered and no fired pattern is waiting.
- R10: `evt_clr` clears every match flag, every waiting report and the offered address in one cycle. Stored words and ignore codes are kept.
- R11: After reset, `res_valid` is low and `res_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_clr | input | 1 | Event clear: drops all match flags and reports |
| ld_en | input | 1 | Pattern write strobe |
| ld_pat | input | 6 | Pattern address for the write |
| ld_layer | input | 3 | Layer index for the write |
| ld_word | input | 16 | Reference word to store |
| ld_ign | input | 3 | Ignore code (low bits masked, clamped 2..6) |
| thr | input | 4 | Majority threshold (0 acts as 1) |
| bus_valid | input | 8 | Per-layer input valid |
| bus_word | input | 128 | Per-layer input words, layer l at bits 16l+15:16l |
| res_valid | output | 1 | A fired pattern address is offered |
| res_ready | input | 1 | Consumer accepts the offered address |
| res_addr | output | 6 | Offered pattern address |
| res_done | output | 1 | Nothing offered and nothing waiting |

## Verification
The bench loads all 64 patterns with distinct words and drives the bank with several kinds of hits:
- All eight layers of one pattern in a single cycle, which tests the basic latency and hold behaviour.
- Layers spread one per cycle, with a masked-off word in between, which separates sticky flags and the valid gate from plain per-cycle matching.
- Partial hits against a raised threshold, which show the majority boundary on both sides.
- Three patterns completed by one shared final word, which shows whether simultaneous fires leave in ascending order and only once.
- Words that differ just inside and just outside the ignored low bits, for several ignore codes, which locate the mask boundary and the clamping.
- A write issued during an event clear, which separates dropped writes from accepted ones.

// File: rtl/am_pkg.sv
package am_pkg;

  // Number of ignored low bits for a stored code, limited to [lo, hi].
  function automatic int ign_count(input int code, input int lo, input int hi);
    int n;
    n = code;
    if (n < lo) n = lo;
    if (n > hi) n = hi;
    return n;
  endfunction

  // Mask of compared bits (ones above the ignored low bits), up to 32 bits wide.
  function automatic logic [31:0] care_bits(input int ign);
    return 32'hFFFF_FFFF << ign;
  endfunction

endpackage

// File: rtl/am_cell.sv
module am_cell
  import am_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IGN_W  = 3,
  parameter int IGN_LO = 2,
  parameter int IGN_HI = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_clr,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IGN_W-1:0]  wr_ign,
  input  logic              hit_valid,
  input  logic [WORD_W-1:0] hit_word,
  output logic              matched
);

  logic [WORD_W-1:0] ref_word;
  logic [IGN_W-1:0]  ref_ign;
  logic [31:0]       care_full;
  logic [WORD_W-1:0] care;
  logic              hit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_word <= '0;
      ref_ign  <= IGN_W'(IGN_LO);
    end else if (wr_sel) begin
      ref_word <= wr_word;
      ref_ign  <= wr_ign;
    end
  end

  always_comb begin
    care_full = care_bits(ign_count(int'(ref_ign), IGN_LO, IGN_HI));
    care      = care_full[WORD_W-1:0];
    hit_now   = hit_valid && (((hit_word ^ ref_word) & care) == '0);
  end

  // Sticky match flag; event clear wins over a same-cycle hit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       matched <= 1'b0;
    else if (evt_clr) matched <= 1'b0;
    else if (hit_now) matched <= 1'b1;
  end

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (matched && !evt_clr) |=> matched);

  p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_valid && !matched) |=> !matched);

endmodule

// File: rtl/am_pattern.sv
module am_pattern #(
  parameter int WORD_W    = 16,
  parameter int IGN_W     = 3,
  parameter int IGN_LO    = 2,
  parameter int IGN_HI    = 6,
  parameter int NUM_LAYER = 8,
  parameter int LAYER_W   = $clog2(NUM_LAYER),
  parameter int THR_W     = $clog2(NUM_LAYER + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        evt_clr,
  input  logic                        wr_pat_sel,
  input  logic [LAYER_W-1:0]          wr_layer,
  input  logic [WORD_W-1:0]           wr_word,
  input  logic [IGN_W-1:0]            wr_ign,
  input  logic [NUM_LAYER-1:0]        hit_valid,
  input  logic [NUM_LAYER*WORD_W-1:0] hit_word,
  input  logic [THR_W-1:0]            thr,
  output logic                        fired
);

  logic [NUM_LAYER-1:0] flag;
  logic [THR_W-1:0]     cnt;
  logic [THR_W-1:0]     thr_eff;

  for (genvar l = 0; l < NUM_LAYER; l++) begin : g_layer
    am_cell #(
      .WORD_W(WORD_W), .IGN_W(IGN_W), .IGN_LO(IGN_LO), .IGN_HI(IGN_HI)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_clr  (evt_clr),
      .wr_sel   (wr_pat_sel && (wr_layer == LAYER_W'(l))),
      .wr_word  (wr_word),
      .wr_ign   (wr_ign),
      .hit_valid(hit_valid[l]),
      .hit_word (hit_word[l*WORD_W +: WORD_W]),
      .matched  (flag[l])
    );
  end

  // Majority count of flagged layers.
  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_LAYER; i++) cnt = cnt + THR_W'(flag[i]);
    thr_eff = (thr == '0) ? THR_W'(1) : thr;
    fired   = (cnt >= thr_eff);
  end

endmodule

// File: rtl/am_readout.sv
module am_readout #(
  parameter int NUM_PAT = 64,
  parameter int ADDR_W  = $clog2(NUM_PAT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_clr,
  input  logic [NUM_PAT-1:0] fired,
  input  logic               res_ready,
  output logic               res_valid,
  output logic [ADDR_W-1:0]  res_addr,
  output logic               res_done
);

  logic [NUM_PAT-1:0] claimed;
  logic [NUM_PAT-1:0] pending;
  logic [ADDR_W-1:0]  pick;
  logic               any_pending;

  always_comb begin
    pending     = fired & ~claimed;
    any_pending = |pending;
    pick        = '0;
    for (int i = NUM_PAT - 1; i >= 0; i--) begin
      if (pending[i]) pick = ADDR_W'(i);
    end
  end

  // Output register: loads the lowest waiting pattern when empty or accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claimed   <= '0;
      res_valid <= 1'b0;
      res_addr  <= '0;
    end else if (evt_clr) begin
      claimed   <= '0;
      res_valid <= 1'b0;
      res_addr  <= '0;
    end else if (!res_valid || res_ready) begin
      res_valid <= any_pending;
      if (any_pending) begin
        res_addr      <= pick;
        claimed[pick] <= 1'b1;
      end
    end
  end

  assign res_done = !res_valid && !any_pending;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !evt_clr) |=> (res_valid && $stable(res_addr)));

  p_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !evt_clr) |=> !(res_valid && res_addr == $past(res_addr)));

endmodule

// File: rtl/am_pattern_bank.sv
module am_pattern_bank #(
  parameter int NUM_PAT   = 64,
  parameter int NUM_LAYER = 8,
  parameter int WORD_W    = 16,
  parameter int IGN_W     = 3,
  parameter int IGN_LO    = 2,
  parameter int IGN_HI    = 6,
  parameter int ADDR_W    = $clog2(NUM_PAT),
  parameter int LAYER_W   = $clog2(NUM_LAYER),
  parameter int THR_W     = $clog2(NUM_LAYER + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        evt_clr,
  input  logic                        ld_en,
  input  logic [ADDR_W-1:0]           ld_pat,
  input  logic [LAYER_W-1:0]          ld_layer,
  input  logic [WORD_W-1:0]           ld_word,
  input  logic [IGN_W-1:0]            ld_ign,
  input  logic [THR_W-1:0]            thr,
  input  logic [NUM_LAYER-1:0]        bus_valid,
  input  logic [NUM_LAYER*WORD_W-1:0] bus_word,
  output logic                        res_valid,
  input  logic                        res_ready,
  output logic [ADDR_W-1:0]           res_addr,
  output logic                        res_done
);

  logic               ld_go;
  logic [NUM_PAT-1:0] fired;

  // Writes arriving together with an event clear are dropped.
  assign ld_go = ld_en && !evt_clr;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    am_pattern #(
      .WORD_W(WORD_W), .IGN_W(IGN_W), .IGN_LO(IGN_LO), .IGN_HI(IGN_HI),
      .NUM_LAYER(NUM_LAYER), .LAYER_W(LAYER_W), .THR_W(THR_W)
    ) u_pat (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_clr   (evt_clr),
      .wr_pat_sel(ld_go && (ld_pat == ADDR_W'(p))),
      .wr_layer  (ld_layer),
      .wr_word   (ld_word),
      .wr_ign    (ld_ign),
      .hit_valid (bus_valid),
      .hit_word  (bus_word),
      .thr       (thr),
      .fired     (fired[p])
    );
  end

  am_readout #(.NUM_PAT(NUM_PAT), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_clr  (evt_clr),
    .fired    (fired),
    .res_ready(res_ready),
    .res_valid(res_valid),
    .res_addr (res_addr),
    .res_done (res_done)
  );

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (!res_valid && res_done));

endmodule

// File: tb/am_pattern_bank_bench.sv
module am_pattern_bank_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_clr = 1'b0;
  logic         ld_en = 1'b0;
  logic [5:0]   ld_pat = '0;
  logic [2:0]   ld_layer = '0;
  logic [15:0]  ld_word = '0;
  logic [2:0]   ld_ign = '0;
  logic [3:0]   thr = 4'd8;
  logic [7:0]   bus_valid = '0;
  logic [127:0] bus_word = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [5:0]   res_addr;
  logic         res_done;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  am_pattern_bank u_am_pattern_bank (
    .clk(clk), .rst_n(rst_n), .evt_clr(evt_clr),
    .ld_en(ld_en), .ld_pat(ld_pat), .ld_layer(ld_layer), .ld_word(ld_word), .ld_ign(ld_ign),
    .thr(thr), .bus_valid(bus_valid), .bus_word(bus_word),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr), .res_done(res_done)
  );

  function automatic logic [15:0] enc(input int p, input int l);
    return 16'((p << 10) | (l << 7));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(input int p, input int l, input logic [15:0] w, input int ign, input logic clr);
    @(negedge clk);
    ld_en = 1'b1; ld_pat = 6'(p); ld_layer = 3'(l); ld_word = w; ld_ign = 3'(ign); evt_clr = clr;
    @(negedge clk);
    ld_en = 1'b0; evt_clr = 1'b0;
  endtask

  // Presents pattern p's words on every layer, valid on the layers in mask.
  task automatic hits(input int p, input logic [7:0] mask);
    @(negedge clk);
    for (int l = 0; l < 8; l++) bus_word[l*16 +: 16] = enc(p, l);
    bus_valid = mask;
    @(negedge clk);
    bus_valid = '0;
  endtask

  task automatic hit_layer(input int l, input logic [15:0] w);
    @(negedge clk);
    bus_word[l*16 +: 16] = w;
    bus_valid = 8'(1 << l);
    @(negedge clk);
    bus_valid = '0;
  endtask

  task automatic clear();
    @(negedge clk); evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 valid after reset", res_valid, 0);
    check("R11 done after reset", res_done, 1);
  endtask

  task automatic t_single();
    thr = 4'd8; res_ready = 1'b0;
    hits(5, 8'hFF);
    @(negedge clk);
    check("R6 valid after full hit", res_valid, 1);
    check("R6 address of full hit", res_addr, 5);
    check("R9 done low while offered", res_done, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 valid held", res_valid, 1);
      check("R7 address held", res_addr, 5);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R8 no repeat after accept", res_valid, 0);
    check("R9 done after drain", res_done, 1);
    clear();
  endtask

  task automatic t_staggered();
    thr = 4'd8;
    for (int l = 0; l < 7; l++) hits(9, 8'(1 << l));
    hits(9, 8'h00);
    @(negedge clk);
    check("R2 word with valid low ignored", res_valid, 0);
    hits(9, 8'h80);
    @(negedge clk);
    check("R3 staggered layers fire", res_valid, 1);
    check("R3 staggered address", res_addr, 9);
    clear();
  endtask

  task automatic t_majority();
    thr = 4'd6;
    hits(20, 8'h1F);
    @(negedge clk); @(negedge clk);
    check("R5 five of six is below threshold", res_valid, 0);
    hits(20, 8'h20);
    @(negedge clk);
    check("R5 threshold reached", res_valid, 1);
    check("R5 threshold address", res_addr, 20);
    clear();
    thr = 4'd0;
    hits(21, 8'h01);
    @(negedge clk);
    check("R5 threshold zero acts as one", res_valid, 1);
    check("R5 threshold zero address", res_addr, 21);
    clear();
  endtask

  task automatic t_order();
    thr = 4'd8; res_ready = 1'b0;
    write(3, 7, enc(63, 7), 2, 1'b0);
    write(17, 7, enc(63, 7), 2, 1'b0);
    write(40, 7, enc(63, 7), 2, 1'b0);
    hits(40, 8'h7F); hits(3, 8'h7F); hits(17, 8'h7F);
    @(negedge clk); @(negedge clk);
    check("R1 rewritten layer not yet hit", res_valid, 0);
    hit_layer(7, enc(63, 7));
    res_ready = 1'b1;
    @(negedge clk);
    check("R6 first ascending", res_addr, 3);
    @(negedge clk);
    check("R6 second ascending", res_addr, 17);
    @(negedge clk);
    check("R6 third ascending", res_addr, 40);
    check("R6 third valid", res_valid, 1);
    @(negedge clk);
    check("R9 done after three", res_done, 1);
    hits(3, 8'h7F);
    hit_layer(7, enc(63, 7));
    @(negedge clk);
    check("R8 rehit not reported", res_valid, 0);
    res_ready = 1'b0;
    clear();
  endtask

  task automatic dc_case(input int ign, input logic [15:0] low, input int exp, input string tag);
    write(30, 0, enc(30, 0), ign, 1'b0);
    hit_layer(0, enc(30, 0) | low);
    @(negedge clk);
    check(tag, res_valid, exp);
    if (exp == 1) check("R4 address", res_addr, 30);
    clear();
  endtask

  task automatic t_dontcare();
    thr = 4'd1;
    dc_case(5, 16'h001F, 1, "R4 code 5 ignores five bits");
    dc_case(5, 16'h0020, 0, "R4 code 5 compares bit 5");
    dc_case(1, 16'h0003, 1, "R4 code 1 acts as 2");
    dc_case(1, 16'h0004, 0, "R4 code 1 compares bit 2");
    dc_case(7, 16'h003F, 1, "R4 code 7 acts as 6");
    dc_case(7, 16'h0040, 0, "R4 code 7 compares bit 6");
    write(30, 0, enc(30, 0), 2, 1'b0);
  endtask

  task automatic t_clear_write();
    thr = 4'd1; res_ready = 1'b0;
    write(50, 0, 16'h0155, 2, 1'b1);
    hit_layer(0, 16'h0155);
    @(negedge clk);
    check("R1 write during clear dropped", res_valid, 0);
    hit_layer(0, enc(50, 0));
    @(negedge clk);
    check("R10 stored word survives clear", res_valid, 1);
    check("R10 address", res_addr, 50);
    clear();
    check("R10 clear drops offered address", res_valid, 0);
    check("R10 done after clear", res_done, 1);
    hit_layer(0, enc(50, 0));
    @(negedge clk);
    check("R10 new event reports again", res_addr, 50);
    clear();
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int p = 0; p < 64; p++)
      for (int l = 0; l < 8; l++) write(p, l, enc(p, l), 2, 1'b0);
    t_single();
    t_staggered();
    t_majority();
    t_order();
    t_dontcare();
    t_clear_write();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule